// File: doc/BRIEF.md
# 64B/66B Block Synchronizer

This block sits behind a serial-to-parallel converter that delivers 66-bit words whose block boundary is unknown. It keeps the previous word next to the incoming one. From that 132-bit span it can cut a 66-bit block starting at any of the 66 bit positions. Bit 0 of each word is the earliest bit on the line. A block is a 2-bit sync header in its two lowest bits, followed by 64 scrambled payload bits. Only the header patterns 01 and 10 are legal, and at the true boundary every block carries one of them. The block therefore tests the header at its current offset. It moves the offset one bit at a time until legal headers arrive steadily, and then reports lock.

Losing lock uses hysteresis. Once locked, the block counts bad headers in fixed windows of blocks, and it only gives up when too many fall inside one window. Both data interfaces use valid/ready. A word is taken when `in_valid` and `in_ready` are both high on a rising edge. An offered output block must be held unchanged until the consumer takes it with `out_ready`. `in_ready` is low only while an output block waits unconsumed, so back-pressure reaches the source directly with no extra storage. `block_lock` and `slip_count` are plain status pins.

Top module: `block_sync_66`

## Requirements
- R1: After reset `out_valid`, `block_lock` and `slip_count` are 0, `in_ready` is 1 and the bit offset is 0.
- R2: `in_ready` equals `!out_valid || out_ready`. Each accepted word except the first one after reset produces exactly one output block. While `out_valid` is high and `out_ready` is low, `out_block` and `out_hdr_ok` hold their values.
- R3: The output block for an accepted word is bits `s` to `s+65` of the 132-bit value {accepted word, previously accepted word}, where `s` (0 to 65) is the current offset.
- R4: `out_hdr_ok` is 1 exactly when the two lowest bits of `out_block` are 01 or 10, and 0 for 00 or 11.
- R5: The first accepted word after reset, and the first accepted word after each slip, are not tested: their header changes no counter, no lock state and no offset.
- R6: While unlocked, a tested invalid header causes a slip. The offset steps by one and wraps from 65 to 0, the run of valid headers restarts, and `slip_count` increases by one.
- R7: While unlocked, `block_lock` rises with the 64th consecutive tested valid header at one offset.
- R8: While locked, tested blocks are grouped into windows of 64, and the bad-header count clears at the end of each window. The 16th invalid header inside one window drops `block_lock` and causes a slip. Fewer than 16 leave lock unchanged.
- R9: `slip_count` saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw word offered |
| in_ready | output | 1 | Raw word can be taken this cycle |
| in_word | input | 66 | Raw unaligned word, bit 0 earliest |
| out_valid | output | 1 | Aligned block offered |
| out_ready | input | 1 | Consumer takes the offered block |
| out_block | output | 66 | Block cut at the current offset |
| out_hdr_ok | output | 1 | Header of `out_block` is 01 or 10 |
| block_lock | output | 1 | Block boundary found |
| slip_count | output | SLIP_W | Saturating count of slips |

## Verification
The hardest case to reach from the ports is lock loss in exactly the right form. The bench must put enough bad headers into one window, counted against a window phase that cannot be seen at the pins, while a near-miss burst elsewhere must leave lock standing. The stimulus builds a real bit stream from blocks with a chosen bit phase and injects bursts of illegal headers at the true boundary: a 15-block burst, and later a 40-block burst that must overlap some window by at least 16. A bench model of the hunting and hysteresis rules follows every accepted word, so window phase, skipped blocks and offset wrap-around are all checked under random back-pressure. Phase changes force the offset through 37, then 65, then back to 0.

// File: rtl/blksync_pkg.sv
package blksync_pkg;

  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } sync_st_e;

  // a header is legal when its two bits differ
  function automatic logic hdr_legal(input logic [1:0] hdr);
    return hdr[0] ^ hdr[1];
  endfunction

endpackage

// File: rtl/blksync_align.sv
module blksync_align
  import blksync_pkg::*;
#(
  parameter int BLK_W = 66
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic [BLK_W-1:0]         in_word,
  input  logic [$clog2(BLK_W)-1:0] offset,
  output logic [BLK_W-1:0]         cand,
  output logic                     cand_hdr_ok,
  output logic                     primed
);
  localparam int OFF_W  = $clog2(BLK_W);
  localparam int SPAN_W = 2 * BLK_W;

  logic [BLK_W-1:0]  prev_q;
  logic              primed_q;
  logic [SPAN_W-1:0] span;
  logic [BLK_W-1:0]  tap [BLK_W];

  assign span = {in_word, prev_q};

  for (genvar g = 0; g < BLK_W; g++) begin : g_tap
    assign tap[g] = span[g +: BLK_W];
  end

  always_comb begin
    cand = tap[0];
    for (int i = 1; i < BLK_W; i++) begin
      if (offset == OFF_W'(i)) cand = tap[i];
    end
  end

  assign cand_hdr_ok = hdr_legal(cand[1:0]);
  assign primed      = primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (fire) begin
      prev_q   <= in_word;
      primed_q <= 1'b1;
    end
  end

  assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    offset < OFF_W'(BLK_W));

  assert_primed_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> primed_q);

endmodule

// File: rtl/blksync_lock.sv
module blksync_lock
  import blksync_pkg::*;
#(
  parameter int BLK_W    = 66,
  parameter int LOCK_RUN = 64,
  parameter int WIN_LEN  = 64,
  parameter int BAD_LIM  = 16,
  parameter int SLIP_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     test_en,
  input  logic                     hdr_ok,
  output logic [$clog2(BLK_W)-1:0] offset,
  output logic                     block_lock,
  output logic [SLIP_W-1:0]        slip_count
);
  localparam int OFF_W  = $clog2(BLK_W);
  localparam int GOOD_W = $clog2(LOCK_RUN);
  localparam int WIN_W  = $clog2(WIN_LEN);
  localparam int BAD_W  = $clog2(BAD_LIM);

  sync_st_e          st_q;
  logic              skip_q;
  logic [GOOD_W-1:0] good_q;
  logic [WIN_W-1:0]  win_q;
  logic [BAD_W-1:0]  bad_q;
  logic [OFF_W-1:0]  off_q;
  logic [SLIP_W-1:0] slips_q;

  logic              tested;
  logic              lose;
  logic              slip;
  logic [OFF_W-1:0]  next_off;

  assign tested   = test_en && !skip_q;
  assign lose     = (st_q == ST_LOCKED) && !hdr_ok && (bad_q == BAD_W'(BAD_LIM - 1));
  assign slip     = tested && !hdr_ok && ((st_q == ST_HUNT) || lose);
  assign next_off = (off_q == OFF_W'(BLK_W - 1)) ? '0 : off_q + OFF_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_HUNT;
      skip_q  <= 1'b1;
      good_q  <= '0;
      win_q   <= '0;
      bad_q   <= '0;
      off_q   <= '0;
      slips_q <= '0;
    end else if (test_en) begin
      if (skip_q) begin
        skip_q <= 1'b0;
      end else if (st_q == ST_HUNT) begin
        if (hdr_ok) begin
          if (good_q == GOOD_W'(LOCK_RUN - 1)) begin
            st_q   <= ST_LOCKED;
            good_q <= '0;
            win_q  <= '0;
            bad_q  <= '0;
          end else begin
            good_q <= good_q + GOOD_W'(1);
          end
        end
      end else if (lose) begin
        st_q <= ST_HUNT;
      end else if (win_q == WIN_W'(WIN_LEN - 1)) begin
        win_q <= '0;
        bad_q <= '0;
      end else begin
        win_q <= win_q + WIN_W'(1);
        bad_q <= bad_q + BAD_W'(!hdr_ok);
      end
      if (slip) begin
        off_q  <= next_off;
        good_q <= '0;
        skip_q <= 1'b1;
        if (~&slips_q) slips_q <= slips_q + SLIP_W'(1);
      end
    end
  end

  assign offset     = off_q;
  assign block_lock = (st_q == ST_LOCKED);
  assign slip_count = slips_q;

  assert_lock_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_lock) |-> ($past(good_q) == GOOD_W'(LOCK_RUN - 1)) && $past(hdr_ok));

  assert_slip_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_count != $past(slip_count)) |->
      (off_q == (($past(off_q) == OFF_W'(BLK_W - 1)) ? '0 : $past(off_q) + OFF_W'(1))));

  assert_skip_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && skip_q) |=> $stable(off_q) && $stable(good_q) && $stable(st_q));

  assert_loss_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(block_lock) |-> ($past(bad_q) == BAD_W'(BAD_LIM - 1)) && !$past(hdr_ok));

  assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&slips_q) |=> (&slips_q));

endmodule

// File: rtl/blksync_out.sv
module blksync_out #(
  parameter int BLK_W = 66
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             primed,
  input  logic [BLK_W-1:0] cand,
  input  logic             cand_hdr_ok,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_block,
  output logic             out_hdr_ok
);
  logic             vld_q;
  logic [BLK_W-1:0] blk_q;
  logic             hok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      blk_q <= '0;
      hok_q <= 1'b0;
    end else if (fire) begin
      vld_q <= primed;
      blk_q <= cand;
      hok_q <= cand_hdr_ok;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_block  = blk_q;
  assign out_hdr_ok = hok_q;

  assert_hold_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_block) && $stable(out_hdr_ok));

  assert_hdr_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hdr_ok == (out_block[0] != out_block[1])));

endmodule

// File: rtl/block_sync_66.sv
module block_sync_66
  import blksync_pkg::*;
#(
  parameter int BLK_W    = 66,
  parameter int LOCK_RUN = 64,
  parameter int WIN_LEN  = 64,
  parameter int BAD_LIM  = 16,
  parameter int SLIP_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_block,
  output logic              out_hdr_ok,
  output logic              block_lock,
  output logic [SLIP_W-1:0] slip_count
);
  localparam int OFF_W = $clog2(BLK_W);

  logic             fire;
  logic [OFF_W-1:0] offset;
  logic [BLK_W-1:0] cand;
  logic             cand_hdr_ok;
  logic             primed;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  blksync_align #(.BLK_W(BLK_W)) u_align (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .in_word     (in_word),
    .offset      (offset),
    .cand        (cand),
    .cand_hdr_ok (cand_hdr_ok),
    .primed      (primed)
  );

  blksync_lock #(
    .BLK_W    (BLK_W),
    .LOCK_RUN (LOCK_RUN),
    .WIN_LEN  (WIN_LEN),
    .BAD_LIM  (BAD_LIM),
    .SLIP_W   (SLIP_W)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .test_en    (fire),
    .hdr_ok     (cand_hdr_ok),
    .offset     (offset),
    .block_lock (block_lock),
    .slip_count (slip_count)
  );

  blksync_out #(.BLK_W(BLK_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .primed      (primed),
    .cand        (cand),
    .cand_hdr_ok (cand_hdr_ok),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_block   (out_block),
    .out_hdr_ok  (out_hdr_ok)
  );

  assert_ready_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/test_block_sync_66.sv
module test_block_sync_66;
  localparam int W        = 66;
  localparam int SW       = 4;
  localparam int SLIP_MAX = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_word = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_block;
  logic          out_hdr_ok;
  logic          block_lock;
  logic [SW-1:0] slip_count;

  always #2 clk = ~clk;

  block_sync_66 #(.SLIP_W(SW)) i_block_sync_66 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block),
    .out_hdr_ok(out_hdr_ok), .block_lock(block_lock), .slip_count(slip_count)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---- reference model of the requirements ----
  logic [W-1:0] m_prev = '0;
  bit m_primed = 0, m_skip = 1, m_locked = 0;
  int m_good = 0, m_win = 0, m_badc = 0, m_off = 0, m_slips = 0;
  bit e_valid = 0, e_hdr = 0, exp_v = 0, pend_chk = 0, hold_pend = 0;
  logic [W-1:0] e_block = '0, hold_blk = '0;

  task automatic m_slip();
    m_off   = (m_off == W - 1) ? 0 : m_off + 1;   // R6 wrap
    m_good  = 0;
    m_skip  = 1;
    if (m_slips < SLIP_MAX) m_slips++;            // R9
  endtask

  task automatic model_step(input logic [W-1:0] w);
    logic [2*W-1:0] sp;
    bit hv;
    sp = {w, m_prev} >> m_off;
    e_block = sp[W-1:0];
    hv = e_block[0] ^ e_block[1];
    e_hdr = hv;
    e_valid = m_primed;
    if (m_skip) m_skip = 0;                       // R5
    else if (!m_locked) begin
      if (hv) begin
        if (m_good == 63) begin m_locked = 1; m_good = 0; m_win = 0; m_badc = 0; end
        else m_good++;
      end else m_slip();
    end else begin
      if (!hv && m_badc == 15) begin m_locked = 0; m_slip(); end
      else if (m_win == 63) begin m_win = 0; m_badc = 0; end
      else begin m_win++; if (!hv) m_badc++; end
    end
    m_prev = w;
    m_primed = 1;
  endtask

  // ---- stream generator ----
  logic [W-1:0] g_cur = '0, g_next = '0, pend_w = '0;
  int g_d = 0, bad_burst = 0, bad_pct = 0, stall_pct = 0;
  bit have_w = 0;

  function automatic logic [W-1:0] gen_block(input bit bad);
    logic [1:0] h;
    if (bad) h = ($urandom % 2) ? 2'b00 : 2'b11;
    else     h = ($urandom % 2) ? 2'b01 : 2'b10;
    return {$urandom(), $urandom(), h};
  endfunction

  task automatic next_word();
    logic [2*W-1:0] sp;
    bit bad;
    sp = {g_next, g_cur} >> g_d;
    pend_w = sp[W-1:0];
    g_cur = g_next;
    if (bad_burst > 0) begin bad = 1; bad_burst--; end
    else bad = (($urandom % 100) < bad_pct);
    g_next = gen_block(bad);
  endtask

  task automatic check_outputs();
    chk(out_valid == exp_v, "R2", "out_valid", W'(out_valid), W'(exp_v));
    if (hold_pend) begin
      chk(out_block == hold_blk, "R2", "held block", out_block, hold_blk);
      hold_pend = 0;
    end
    if (pend_chk) begin
      if (e_valid) begin
        chk(out_block == e_block, "R3", "block", out_block, e_block);
        chk(out_hdr_ok == e_hdr, "R4", "hdr_ok", W'(out_hdr_ok), W'(e_hdr));
      end
      chk(block_lock == m_locked, "R7/R8 lock", "block_lock", W'(block_lock), W'(m_locked));
      chk(int'(slip_count) == m_slips, "R6 slips", "slip_count", W'(slip_count), W'(m_slips));
      pend_chk = 0;
    end
  endtask

  task automatic step(input bit want, output bit took);
    bit fire;
    @(negedge clk);
    check_outputs();
    out_ready = (($urandom % 100) >= stall_pct);
    if (want && !have_w) begin next_word(); have_w = 1; end
    in_valid = want && (($urandom % 100) >= stall_pct);
    in_word = pend_w;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R2", "in_ready", W'(in_ready), W'(!out_valid || out_ready));
    fire = in_valid && in_ready;
    if (out_valid && !out_ready) begin hold_pend = 1; hold_blk = out_block; end
    if (fire) begin
      model_step(pend_w);
      have_w = 0;
      exp_v = e_valid;
      pend_chk = 1;
    end else if (out_ready) exp_v = 0;
    took = fire;
  endtask

  task automatic run(input int n);
    bit t;
    int got = 0;
    while (got < n) begin
      step(1, t);
      if (t) got++;
    end
    stall_pct = 0;
    step(0, t);
    step(0, t);
  endtask

  initial begin
    void'($urandom(32'h5EED_0066));
    g_cur = gen_block(0);
    g_next = gen_block(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 0, "R1", "out_valid", W'(out_valid), '0);
    chk(block_lock == 0, "R1", "block_lock", W'(block_lock), '0);
    chk(slip_count == 0, "R1", "slip_count", W'(slip_count), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1, "R1", "in_ready", W'(in_ready), W'(1));

    // R7: aligned stream, 1 skipped + 64 valid headers gives lock
    g_d = 0;
    run(64);
    chk(block_lock == 0, "R7", "lock after 63 tested", W'(block_lock), '0);
    run(1);
    chk(block_lock == 1, "R7", "lock after 64 tested", W'(block_lock), W'(1));
    chk(slip_count == 0, "R6", "no slips on aligned stream", W'(slip_count), '0);

    // R2 under back-pressure while locked
    stall_pct = 30; run(200);
    chk(block_lock == 1, "R2", "lock kept under stalls", W'(block_lock), W'(1));

    // R8: 15 bad headers keep lock
    bad_burst = 15; run(20);
    chk(block_lock == 1, "R8", "15 bad keep lock", W'(block_lock), W'(1));
    run(80);
    // R8: long burst drops lock
    bad_burst = 40; run(45);
    chk(block_lock == 0, "R8", "burst drops lock", W'(block_lock), '0);

    // R6 hunt at other phases, including wrap 65 -> 0
    g_d = 29; run(600);
    chk(block_lock == 1, "R6", "relock phase 29", W'(block_lock), W'(1));
    g_d = 1; stall_pct = 20; run(600);
    chk(block_lock == 1, "R6", "relock phase 1", W'(block_lock), W'(1));
    g_d = 0; run(600);
    chk(block_lock == 1, "R6", "relock after wrap", W'(block_lock), W'(1));

    // random mix
    bad_pct = 2; stall_pct = 25; g_d = ($urandom % 66);
    run(1500);
    bad_pct = 0;
    chk(slip_count == SW'(SLIP_MAX), "R9", "slip_count saturated", W'(slip_count), W'(SLIP_MAX));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule